// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous 32K x 8 static RAM. The host hands it one read or one write at a time through a valid/ready handshake. The block then produces the RAM's strobe sequence from registered outputs. It drives an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. It also drives a data bus split into out, in and drive-enable, which feeds an external tri-state pad.

No ready signal comes back from the RAM. The block meets every pulse width, setup, hold, access and bus-turnaround window by counting clock cycles, and each window is a parameter. Both chip-level enables are asserted for the whole of an access and released when the block is idle.

A write has three phases: a setup cycle, a strobe phase that drives the data, and a recovery phase that keeps the address and select steady. A read has a setup cycle, then an output-enable window, then a sample of the data pins. When a write follows a read, a turnaround gap comes first, so that the RAM has let go of the bus before the block drives it.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, mem_cs_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, rd_valid=0 and req_ready=1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access ends. During an access mem_cs_n=0 and mem_ce=1. Whenever req_ready=1, mem_cs_n=1 and mem_ce=0.
- R3: A write (req_write=1) is sequenced in three phases. First comes one setup cycle with the address and select driven and mem_we_n=1. Then mem_we_n=0 for exactly T_WP cycles while req_wdata is driven on mem_dq_out. Then mem_we_n=1 for T_WR recovery cycles. req_ready is 0 for 1+T_WP+T_WR cycles.
- R4: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0, so the bus is released on the same edge where mem_we_n rises.
- R5: mem_addr is unchanged from the cycle before mem_we_n falls until the cycle after it rises, and mem_cs_n is 0 on both sides of the strobe.
- R6: A read (req_write=0) has one setup cycle and then mem_oe_n=0 for T_ACC+1 cycles. mem_dq_in is sampled on the edge that ends this window. rd_data shows the sample with rd_valid=1 for one cycle, the first cycle in which req_ready is 1 again. req_ready is 0 for T_ACC+2 cycles.
- R7: mem_we_n and mem_oe_n are never 0 in the same cycle.
- R8: The first write after a completed read first spends T_TURN extra cycles with select active, mem_oe_n=1 and mem_dq_oe=0. Only then does its setup cycle start, so req_ready is 0 for 1+T_TURN+T_WP+T_WR cycles. A write after a write, and any read, gets no such gap.
- R9: rd_data keeps the last read value until the next read completes; writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, request can be taken |
| rd_data | output | 8 | Last read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_addr | output | 15 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM enable, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data toward the pad |
| mem_dq_in | input | 8 | Data from the pad |
| mem_dq_oe | output | 1 | Pad drive enable |

## Verification
The bench uses a RAM model that returns a poison byte until the output enable has been low for the full access window. A read that samples too early therefore shows up as a data mismatch, not just as a timing report. Random mixes of reads and writes go to both a narrow address cluster and the whole address space. The cluster produces many read-after-write hits. The whole space checks all address bits, including the corner addresses 0x0000 and 0x7FFF. Directed sequences of write-write, read-read, read-write and write-read each have their own expected busy length. This length separates the turnaround case from the other three and shows any phase that is too long or too short.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_SETUP = 3'd2,
    ST_WSTRB = 3'd3,
    ST_WREC  = 3'd4,
    ST_RACC  = 3'd5
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_WP   = 4,
  parameter int T_WR   = 1,
  parameter int T_ACC  = 4,
  parameter int T_TURN = 1,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             rd_capture,
  output logic             req_ready
);

  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(T_WR - 1);
  localparam logic [CNT_W-1:0] LD_ACC  = CNT_W'(T_ACC);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'((T_TURN > 0) ? T_TURN - 1 : 0);
  localparam bit               HAS_TURN = (T_TURN > 0);

  seq_state_e state_q;
  logic       op_write_q, op_write_d;
  logic       after_rd_q, after_rd_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rd_capture = 1'b0;
    op_write_d = op_write_q;
    after_rd_d = after_rd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_write_d = req_write;
          if (req_write) begin
            after_rd_d = 1'b0;
          end
          if (req_write && after_rd_q && HAS_TURN) begin
            state_d  = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = LD_TURN;
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_TURN: begin
        if (tmr_expired) begin
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        if (op_write_q) begin
          state_d = ST_WSTRB;
          tmr_val = LD_WP;
        end else begin
          state_d = ST_RACC;
          tmr_val = LD_ACC;
        end
      end
      ST_WSTRB: begin
        if (tmr_expired) begin
          state_d  = ST_WREC;
          tmr_load = 1'b1;
          tmr_val  = LD_WR;
        end
      end
      ST_WREC: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
        end
      end
      ST_RACC: begin
        if (tmr_expired) begin
          state_d    = ST_IDLE;
          rd_capture = 1'b1;
          after_rd_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
      after_rd_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      op_write_q <= op_write_d;
      after_rd_q <= after_rd_d;
    end
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  seq_state_e        state_d,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cs_n_q, ce_q, we_n_q, oe_n_q, dq_oe_q, rvalid_q;
  logic              sel_d, strobe_d, rd_win_d;

  assign sel_d    = (state_d != ST_IDLE);
  assign strobe_d = (state_d == ST_WSTRB);
  assign rd_win_d = (state_d == ST_RACC);

  // Request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Control strobes registered from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q  <= 1'b1;
      ce_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      cs_n_q  <= !sel_d;
      ce_q    <= sel_d;
      we_n_q  <= !strobe_d;
      oe_n_q  <= !rd_win_d;
      dq_oe_q <= strobe_d;
    end
  end

  // Read sample, enabled by rd_capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_capture) begin
      rdata_q <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_ce     = ce_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;
  assign rd_data    = rdata_q;
  assign rd_valid   = rvalid_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int T_WP   = 4,
  parameter int T_WR   = 1,
  parameter int T_ACC  = 4,
  parameter int T_TURN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int MAX_T = max_of(max_of(T_WP, T_WR), max_of(T_ACC + 1, T_TURN));
  localparam int CNT_W = $clog2(MAX_T + 1);

  seq_state_e       state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             rd_capture;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .T_WP(T_WP), .T_WR(T_WR), .T_ACC(T_ACC), .T_TURN(T_TURN), .CNT_W(CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .state_d     (state_d),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .rd_capture  (rd_capture),
    .req_ready   (req_ready)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .state_d    (state_d),
    .rd_capture (rd_capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int T_WP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
    end else if (!mem_we_n) begin
      we_lo_cnt <= we_lo_cnt + 16'd1;
    end else begin
      we_lo_cnt <= '0;
    end
  end

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_ce));

  assert_busy_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (mem_ce && !req_ready));

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(T_WP)));

  assert_bus_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);

  assert_addr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && !$past(mem_cs_n)));

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && !mem_cs_n));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .T_WP(T_WP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_ce    (mem_ce),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;

  localparam int P_WP   = 4;
  localparam int P_WR   = 1;
  localparam int P_ACC  = 4;
  localparam int P_TURN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  dq_in = 8'h5A;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_strobe_ctrl #(
    .T_WP(P_WP), .T_WR(P_WR), .T_ACC(P_ACC), .T_TURN(P_TURN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural RAM model
  logic [7:0]  ram [int];
  logic [7:0]  sb  [int];
  logic [14:0] p_addr = '0;
  logic        p_we_n = 1'b1, p_cs_n = 1'b1, p_rd = 1'b0;
  logic [7:0]  wlat = '0;
  int          rcnt = 0;
  int          wlo = 0;

  function automatic logic [7:0] ram_rd(input logic [14:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] sb_rd(input logic [14:0] a);
    return sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
  endfunction

  function automatic int exp_busy(input bit wr, input bit after_rd);
    if (wr) return 1 + P_WP + P_WR + (after_rd ? P_TURN : 0);
    return P_ACC + 2;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic rd_act;
      rd_act = !mem_cs_n && mem_ce && mem_we_n && !mem_oe_n;
      check(!(!mem_we_n && !mem_oe_n), "R7 we/oe overlap", {mem_we_n, mem_oe_n}, 2'b11);
      check(!(mem_dq_oe && mem_we_n), "R4 bus driven with strobe high", mem_dq_oe, 0);
      check(!(mem_dq_oe && rd_act), "R4 bus contention", mem_dq_oe, 0);
      if (rd_act) begin
        rcnt = (p_rd && mem_addr == p_addr) ? rcnt + 1 : 1;
        dq_in = (rcnt >= P_ACC + 1) ? ram_rd(mem_addr) : 8'hA5;
      end else begin
        rcnt = 0;
        dq_in = 8'h5A;
      end
      if (!mem_we_n) begin
        check(!mem_cs_n && mem_ce, "R3 strobe without select", {mem_cs_n, mem_ce}, 2'b01);
        check(mem_dq_oe, "R4 data not driven in strobe", mem_dq_oe, 1);
        if (p_we_n) begin
          check(mem_addr == p_addr && !p_cs_n, "R5 address setup", mem_addr, p_addr);
          wlo = 1;
        end else begin
          check(mem_addr == p_addr, "R5 address steady", mem_addr, p_addr);
          wlo++;
        end
        wlat = mem_dq_out;
      end else if (!p_we_n) begin
        check(wlo == P_WP, "R3 strobe width", wlo, P_WP);
        check(mem_addr == p_addr && !mem_cs_n, "R5 address hold", mem_addr, p_addr);
        check(!mem_dq_oe, "R4 bus release", mem_dq_oe, 0);
        ram[int'(mem_addr)] = wlat;
      end
      p_rd   = rd_act;
      p_addr = mem_addr;
      p_we_n = mem_we_n;
      p_cs_n = mem_cs_n;
    end
  end

  bit         after_rd = 1'b0;
  bit         have_rd = 1'b0;
  logic [7:0] last_rd = '0;

  task automatic host_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int busy;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    check(!req_ready, "R2 ready drops after accept", req_ready, 0);
    busy = 0;
    while (!req_ready && busy < 100) begin
      busy++;
      @(negedge clk);
    end
    if (wr) begin
      check(busy == exp_busy(1'b1, after_rd),
            after_rd ? "R8 write after read busy length" : "R3 write busy length",
            busy, exp_busy(1'b1, after_rd));
      check(mem_cs_n && !mem_ce, "R2 idle releases select", {mem_cs_n, mem_ce}, 2'b10);
      if (have_rd) check(rd_data == last_rd, "R9 rd_data kept over write", rd_data, last_rd);
      sb[int'(a)] = d;
      after_rd = 1'b0;
    end else begin
      check(busy == exp_busy(1'b0, after_rd), "R6 read busy length", busy, exp_busy(1'b0, after_rd));
      check(rd_valid, "R6 rd_valid at completion", rd_valid, 1);
      check(rd_data == sb_rd(a), "R6 read data", rd_data, sb_rd(a));
      check(mem_cs_n && !mem_ce, "R2 idle releases select", {mem_cs_n, mem_ce}, 2'b10);
      last_rd = rd_data;
      have_rd = 1'b1;
      after_rd = 1'b1;
      @(negedge clk);
      check(!rd_valid, "R6 rd_valid one cycle", rd_valid, 0);
      check(rd_data == last_rd, "R9 rd_data held", rd_data, last_rd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(mem_cs_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 reset pins", {mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    check(req_ready && !rd_valid, "R1 reset handshake", {req_ready, rd_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_cs_n, "R1 idle after release", {req_ready, mem_cs_n}, 2'b11);

    // Directed corners
    host_op(1'b0, 15'h0123, 8'h00);  // read unwritten
    host_op(1'b1, 15'h0000, 8'h3C);  // write after read: turnaround
    host_op(1'b1, 15'h7FFF, 8'hC3);  // write after write
    host_op(1'b0, 15'h7FFF, 8'h00);
    host_op(1'b0, 15'h0000, 8'h00);  // read after read
    host_op(1'b1, 15'h5555, 8'hFF);  // turnaround again
    host_op(1'b1, 15'h2AAA, 8'h01);
    host_op(1'b0, 15'h5555, 8'h00);
    host_op(1'b0, 15'h2AAA, 8'h00);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [14:0] a;
      bit          wr;
      if ($urandom_range(0, 3) != 0) a = 15'($urandom_range(0, 15)) | 15'h4C30;
      else a = 15'($urandom);
      wr = ($urandom_range(0, 1) == 1);
      host_op(wr, a, 8'($urandom));
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule